// File: doc/BRIEF.md
# Incremental Encoder Position Decoder

This block turns the two phase signals of an incremental rotary or linear encoder into counting steps with a direction. It can also treat the same pair of pins as a step clock and a direction level. The steps drive a position counter that stays between zero and a programmable ceiling and wraps at both ends. A separate revolution counter advances once on every index pulse. Three position comparators and one revolution comparator report when a counter equals a programmed value. Single-cycle event pulses report phase errors, direction reversals, counted steps and index pulses.

All three pins first pass through a two-flop synchroniser. A four-state machine then holds the last sampled phase pair. Its states are PH_00, PH_10, PH_11 and PH_01, named by the levels of A and B. Forward rotation (A leading B) walks PH_00 → PH_10 → PH_11 → PH_01 → PH_00, and backward rotation walks the ring the other way. Every clock the machine takes one of four transitions: hold (sample unchanged), forward advance, backward advance, or diagonal (both phases changed, a phase error). It always lands in the newly sampled state. A pin change becomes visible at the outputs after the third rising clock edge that follows it.

Top module: `quad_pos_decoder`

## Requirements
- R1: After reset, position and index_count are 0, dir_status is 1 (forward), and every event output is 0.
- R2: With cfg_clkdir=0 and cfg_x4=1, every single-phase transition counts one step. The sequence AB 00→10→11→01→00 counts up, and the reverse sequence counts down. The new position appears after the third rising clock edge following the pin change.
- R3: With cfg_clkdir=0 and cfg_x4=0, only transitions of phase A count. A transition of phase B alone changes neither position nor ev_enc_clk.
- R4: With cfg_clkdir=1, each rising edge of phase_a is one step: up when phase_b is 1, down when it is 0. Phase B edges do not count, and ev_phase_err is never raised in this mode.
- R5: cfg_dir_inv=1 complements the decoded direction, both for counting and for dir_status.
- R6: In quadrature mode, a sample in which both phases changed pulses ev_phase_err for one cycle and leaves position and dir_status unchanged.
- R7: A step up from a position at or above pos_max gives 0. A step down from 0 gives pos_max.
- R8: dir_status holds the direction of the last counted step (1 = up). ev_dir_change pulses when a counted step's direction differs from the previous dir_status.
- R9: ev_enc_clk pulses for exactly one cycle per counted step.
- R10: The effective index is index_in XOR cfg_idx_inv. Each 0→1 edge of it pulses ev_index and increments index_count, which wraps at its width. Toggling cfg_idx_inv alone produces no index event.
- R11: A clr_pos pulse makes position 0 at the next edge, taking priority over any step. A clr_idx pulse makes index_count 0 at the next edge.
- R12: An arm_pos_on_idx pulse arms the block. At the next index event, position becomes 0 in place of that cycle's step, and the block disarms. Later index events leave position alone.
- R13: ev_pos_match[i] is 1 while position equals slot i of pos_cmp_flat (slot i occupies bits i*POS_W upward). ev_idx_match is 1 while index_count equals idx_cmp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, or step clock in clock/direction mode |
| phase_b | input | 1 | Encoder phase B, or direction level in clock/direction mode |
| index_in | input | 1 | Encoder index pin |
| cfg_clkdir | input | 1 | 0 = quadrature, 1 = clock/direction |
| cfg_x4 | input | 1 | 0 = count phase A edges only, 1 = count edges of both phases |
| cfg_dir_inv | input | 1 | Complement the decoded direction |
| cfg_idx_inv | input | 1 | Invert the index pin sense |
| pos_max | input | POS_W | Position ceiling |
| pos_cmp_flat | input | NCMP*POS_W | Packed position compare values |
| idx_cmp | input | IDX_W | Index count compare value |
| clr_pos | input | 1 | Clear-position strobe |
| arm_pos_on_idx | input | 1 | Arm clear-on-next-index strobe |
| clr_idx | input | 1 | Clear-index-count strobe |
| position | output | POS_W | Position counter |
| index_count | output | IDX_W | Revolution counter |
| dir_status | output | 1 | Direction of last counted step |
| ev_phase_err | output | 1 | Phase error pulse |
| ev_dir_change | output | 1 | Direction reversal pulse |
| ev_enc_clk | output | 1 | Counted step pulse |
| ev_index | output | 1 | Index pulse detected |
| ev_pos_match | output | NCMP | Position equals compare slot |
| ev_idx_match | output | 1 | Index count equals compare value |

## Verification
The assertions assume that the configuration bits and pos_max stay constant whenever the checks that use them look back one cycle. They also assume that the strobes are synchronous single-cycle pulses. The bench changes configuration only while the encoder pins are idle and every event has settled. It holds every pin level for four clocks, so no pin change is lost in the synchroniser, and it raises each strobe for exactly one cycle.

// File: rtl/qpd_pkg.sv
package qpd_pkg;

    // Phase states named by the levels of A and B; forward order is 00,10,11,01
    typedef enum logic [1:0] {
        PH_00 = 2'd0,
        PH_10 = 2'd1,
        PH_11 = 2'd2,
        PH_01 = 2'd3
    } phase_e;

    typedef struct packed {
        logic step;
        logic up;
        logic err;
    } step_t;

    function automatic phase_e to_phase(input logic a, input logic b);
        phase_e p;
        unique case ({a, b})
            2'b00:   p = PH_00;
            2'b10:   p = PH_10;
            2'b11:   p = PH_11;
            default: p = PH_01;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/qpd_sync.sv
module qpd_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= 1'b0;
                stage2[i] <= 1'b0;
            end else begin
                stage1[i] <= din[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign dout = stage2;
endmodule

// File: rtl/qpd_decoder.sv
module qpd_decoder
    import qpd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  a_s,
    input  logic  b_s,
    input  logic  cfg_clkdir,
    input  logic  cfg_x4,
    input  logic  cfg_dir_inv,
    output step_t stp
);
    phase_e state_q;
    phase_e sample;
    phase_e fwd_nxt;
    phase_e bwd_nxt;
    logic   a_prev;
    logic   is_fwd;
    logic   is_bwd;
    logic   is_diag;
    logic   raw_up;
    logic   raw_step;

    assign sample = to_phase(a_s, b_s);

    // State register: always lands in the newly sampled phase pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= sample;
    end

    // Ring neighbours of the present state
    always_comb begin
        unique case (state_q)
            PH_00: begin fwd_nxt = PH_10; bwd_nxt = PH_01; a_prev = 1'b0; end
            PH_10: begin fwd_nxt = PH_11; bwd_nxt = PH_00; a_prev = 1'b1; end
            PH_11: begin fwd_nxt = PH_01; bwd_nxt = PH_10; a_prev = 1'b1; end
            default: begin fwd_nxt = PH_00; bwd_nxt = PH_11; a_prev = 1'b0; end
        endcase
    end

    // Transition classification: hold, forward, backward, diagonal
    always_comb begin
        is_fwd  = (sample == fwd_nxt);
        is_bwd  = (sample == bwd_nxt);
        is_diag = (sample != state_q) && !is_fwd && !is_bwd;
    end

    // Output process
    always_comb begin
        if (cfg_clkdir) begin
            raw_step = a_s && !a_prev;
            raw_up   = b_s;
            stp.err  = 1'b0;
        end else begin
            raw_step = (is_fwd || is_bwd) && (cfg_x4 || (a_s != a_prev));
            raw_up   = is_fwd;
            stp.err  = is_diag;
        end
        stp.step = raw_step;
        stp.up   = raw_up ^ cfg_dir_inv;
    end
endmodule

// File: rtl/qpd_counters.sv
module qpd_counters
    import qpd_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int IDX_W = 8,
    parameter int NCMP  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  step_t                 stp,
    input  logic                  idx_hit,
    input  logic [POS_W-1:0]      pos_max,
    input  logic [NCMP*POS_W-1:0] pos_cmp_flat,
    input  logic [IDX_W-1:0]      idx_cmp,
    input  logic                  clr_pos,
    input  logic                  arm_pos_on_idx,
    input  logic                  clr_idx,
    output logic [POS_W-1:0]      position,
    output logic [IDX_W-1:0]      index_count,
    output logic                  dir_status,
    output logic                  ev_phase_err,
    output logic                  ev_dir_change,
    output logic                  ev_enc_clk,
    output logic                  ev_index,
    output logic [NCMP-1:0]       ev_pos_match,
    output logic                  ev_idx_match
);
    localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic             armed_q;
    logic [POS_W-1:0] pos_nxt;

    always_comb begin
        if (clr_pos)                 pos_nxt = '0;
        else if (armed_q && idx_hit) pos_nxt = '0;
        else if (stp.step && stp.up)
            pos_nxt = (position >= pos_max) ? '0 : position + POS_ONE;
        else if (stp.step)
            pos_nxt = (position == '0) ? pos_max : position - POS_ONE;
        else                         pos_nxt = position;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            position      <= '0;
            index_count   <= '0;
            armed_q       <= 1'b0;
            dir_status    <= 1'b1;
            ev_phase_err  <= 1'b0;
            ev_dir_change <= 1'b0;
            ev_enc_clk    <= 1'b0;
            ev_index      <= 1'b0;
        end else begin
            position      <= pos_nxt;
            armed_q       <= arm_pos_on_idx || (armed_q && !idx_hit);
            if (clr_idx)      index_count <= '0;
            else if (idx_hit) index_count <= index_count + IDX_ONE;
            if (stp.step)     dir_status  <= stp.up;
            ev_phase_err  <= stp.err;
            ev_dir_change <= stp.step && (stp.up != dir_status);
            ev_enc_clk    <= stp.step;
            ev_index      <= idx_hit;
        end
    end

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign ev_pos_match[i] = (position == pos_cmp_flat[i*POS_W +: POS_W]);
    end
    assign ev_idx_match = (index_count == idx_cmp);

    AST_CLR_POS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pos |=> position == '0); // R11
    AST_CLR_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        clr_idx |=> index_count == '0); // R11
    AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pos_max) && $past(position <= pos_max) |-> position <= pos_max); // R7
endmodule

// File: rtl/quad_pos_decoder.sv
module quad_pos_decoder
    import qpd_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int IDX_W = 8,
    parameter int NCMP  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  phase_a,
    input  logic                  phase_b,
    input  logic                  index_in,
    input  logic                  cfg_clkdir,
    input  logic                  cfg_x4,
    input  logic                  cfg_dir_inv,
    input  logic                  cfg_idx_inv,
    input  logic [POS_W-1:0]      pos_max,
    input  logic [NCMP*POS_W-1:0] pos_cmp_flat,
    input  logic [IDX_W-1:0]      idx_cmp,
    input  logic                  clr_pos,
    input  logic                  arm_pos_on_idx,
    input  logic                  clr_idx,
    output logic [POS_W-1:0]      position,
    output logic [IDX_W-1:0]      index_count,
    output logic                  dir_status,
    output logic                  ev_phase_err,
    output logic                  ev_dir_change,
    output logic                  ev_enc_clk,
    output logic                  ev_index,
    output logic [NCMP-1:0]       ev_pos_match,
    output logic                  ev_idx_match
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pins_s;
    logic            idx_raw_q;
    logic            idx_hit;
    step_t           stp;

    qpd_sync #(.W(NPIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({index_in, phase_b, phase_a}),
        .dout (pins_s)
    );

    qpd_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_s        (pins_s[0]),
        .b_s        (pins_s[1]),
        .cfg_clkdir (cfg_clkdir),
        .cfg_x4     (cfg_x4),
        .cfg_dir_inv(cfg_dir_inv),
        .stp        (stp)
    );

    // Index edge: previous raw level kept, both sides seen through the invert bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_raw_q <= 1'b0;
        else        idx_raw_q <= pins_s[2];
    end
    assign idx_hit = (pins_s[2] ^ cfg_idx_inv) && !(idx_raw_q ^ cfg_idx_inv);

    qpd_counters #(.POS_W(POS_W), .IDX_W(IDX_W), .NCMP(NCMP)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .stp           (stp),
        .idx_hit       (idx_hit),
        .pos_max       (pos_max),
        .pos_cmp_flat  (pos_cmp_flat),
        .idx_cmp       (idx_cmp),
        .clr_pos       (clr_pos),
        .arm_pos_on_idx(arm_pos_on_idx),
        .clr_idx       (clr_idx),
        .position      (position),
        .index_count   (index_count),
        .dir_status    (dir_status),
        .ev_phase_err  (ev_phase_err),
        .ev_dir_change (ev_dir_change),
        .ev_enc_clk    (ev_enc_clk),
        .ev_index      (ev_index),
        .ev_pos_match  (ev_pos_match),
        .ev_idx_match  (ev_idx_match)
    );

    AST_NO_ERR_CLKDIR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_phase_err |-> $past(!cfg_clkdir)); // R4
    AST_ERR_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_phase_err && !ev_index && $past(!clr_pos) |-> $stable(position) && $stable(dir_status)); // R6
    AST_DIRCHG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dir_change |-> ev_enc_clk && (dir_status != $past(dir_status))); // R8
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_enc_clk && !ev_index && $past(!clr_pos) && $stable(pos_max) && (pos_max != '0)
        |-> position != $past(position)); // R9
    AST_ERR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_phase_err |-> !ev_enc_clk); // R6
endmodule

// File: tb/quad_pos_decoder_bench.sv
module quad_pos_decoder_bench;
    localparam int POS_W = 16;
    localparam int IDX_W = 8;
    localparam int NCMP  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_a = 0, phase_b = 0, index_in = 0;
    logic cfg_clkdir = 0, cfg_x4 = 1, cfg_dir_inv = 0, cfg_idx_inv = 0;
    logic [POS_W-1:0] pos_max = 16'd20;
    logic [NCMP*POS_W-1:0] pos_cmp_flat = {16'd20, 16'd7, 16'd3};
    logic [IDX_W-1:0] idx_cmp = 8'd2;
    logic clr_pos = 0, arm_pos_on_idx = 0, clr_idx = 0;
    logic [POS_W-1:0] position;
    logic [IDX_W-1:0] index_count;
    logic dir_status, ev_phase_err, ev_dir_change, ev_enc_clk, ev_index, ev_idx_match;
    logic [NCMP-1:0] ev_pos_match;

    always #5 clk = ~clk;

    quad_pos_decoder #(.POS_W(POS_W), .IDX_W(IDX_W), .NCMP(NCMP)) u_quad_pos_decoder (
        .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b), .index_in(index_in),
        .cfg_clkdir(cfg_clkdir), .cfg_x4(cfg_x4), .cfg_dir_inv(cfg_dir_inv), .cfg_idx_inv(cfg_idx_inv),
        .pos_max(pos_max), .pos_cmp_flat(pos_cmp_flat), .idx_cmp(idx_cmp),
        .clr_pos(clr_pos), .arm_pos_on_idx(arm_pos_on_idx), .clr_idx(clr_idx),
        .position(position), .index_count(index_count), .dir_status(dir_status),
        .ev_phase_err(ev_phase_err), .ev_dir_change(ev_dir_change), .ev_enc_clk(ev_enc_clk),
        .ev_index(ev_index), .ev_pos_match(ev_pos_match), .ev_idx_match(ev_idx_match)
    );

    int n_tests = 0, n_fail = 0;
    int n_err = 0, n_dchg = 0, n_clk = 0, n_idx = 0;
    string cur_req = "R1";
    bit done = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_pos = 0, m_idx = 0;
    bit m_dir = 1, m_armed = 0;
    bit m_err = 0, m_dchg = 0, m_clk = 0, m_ie = 0;
    bit q1[3] = '{0, 0, 0};
    bit q2[3] = '{0, 0, 0};
    bit pa = 0, pb = 0, pi = 0;

    function automatic int ord(input bit a, input bit b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_idx = 0; m_dir = 1; m_armed = 0;
            m_err = 0; m_dchg = 0; m_clk = 0; m_ie = 0;
            q1 = '{0, 0, 0}; q2 = '{0, 0, 0}; pa = 0; pb = 0; pi = 0;
        end else begin
            bit st, up, er, ie, ca, cb;
            int mx;
            mx = int'(pos_max);
            ca = q2[0]; cb = q2[1];
            st = 0; up = 0; er = 0;
            if (cfg_clkdir) begin
                if (!pa && ca) begin st = 1; up = cb; end
            end else if ((ca != pa) && (cb != pb)) begin
                er = 1;
            end else if ((ca != pa) || (cb != pb)) begin
                up = (((ord(ca, cb) - ord(pa, pb)) & 3) == 1);
                st = cfg_x4 || (ca != pa);
            end
            if (st) up = up ^ cfg_dir_inv;
            ie = (q2[2] ^ cfg_idx_inv) && !(pi ^ cfg_idx_inv);
            if (clr_pos) m_pos = 0;
            else if (m_armed && ie) m_pos = 0;
            else if (st && up) m_pos = (m_pos >= mx) ? 0 : m_pos + 1;
            else if (st) m_pos = (m_pos == 0) ? mx : m_pos - 1;
            m_armed = arm_pos_on_idx || (m_armed && !ie);
            if (clr_idx) m_idx = 0;
            else if (ie) m_idx = (m_idx + 1) % 256;
            m_dchg = st && (up != m_dir);
            if (st) m_dir = up;
            m_err = er; m_clk = st; m_ie = ie;
            pa = ca; pb = cb; pi = q2[2];
            q2 = q1;
            q1 = '{phase_a, phase_b, index_in};
        end
    end

    // scoreboard and event monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " position"}, position, m_pos);
            chk({cur_req, " index_count"}, index_count, m_idx);
            chk({cur_req, " dir_status"}, dir_status, m_dir);
            chk({cur_req, " ev_phase_err"}, ev_phase_err, m_err);
            chk({cur_req, " ev_dir_change"}, ev_dir_change, m_dchg);
            chk({cur_req, " ev_enc_clk"}, ev_enc_clk, m_clk);
            chk({cur_req, " ev_index"}, ev_index, m_ie);
            chk({cur_req, " pos_match R13"}, ev_pos_match,
                {m_pos == int'(pos_cmp_flat[47:32]), m_pos == int'(pos_cmp_flat[31:16]),
                 m_pos == int'(pos_cmp_flat[15:0])});
            chk({cur_req, " idx_match R13"}, ev_idx_match, m_idx == int'(idx_cmp));
            if (ev_phase_err)  n_err++;
            if (ev_dir_change) n_dchg++;
            if (ev_enc_clk)    n_clk++;
            if (ev_index)      n_idx++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ab(input bit a, input bit b);
        phase_a = a; phase_b = b;
        wcyc(4);
    endtask

    task automatic qstep(input bit fwd);
        int o;
        o = ord(phase_a, phase_b);
        o = fwd ? (o + 1) % 4 : (o + 3) % 4;
        case (o)
            0: set_ab(0, 0);
            1: set_ab(1, 0);
            2: set_ab(1, 1);
            default: set_ab(0, 1);
        endcase
    endtask

    task automatic pulse_index();
        index_in = 1; wcyc(4);
        index_in = 0; wcyc(4);
    endtask

    task automatic strobe(input int which);
        if (which == 0) clr_pos = 1;
        else if (which == 1) clr_idx = 1;
        else arm_pos_on_idx = 1;
        wcyc(1);
        clr_pos = 0; clr_idx = 0; arm_pos_on_idx = 0;
        wcyc(3);
    endtask

    task automatic cd_pulse(input bit dir);
        phase_a = 0; phase_b = dir; wcyc(4);
        phase_a = 1; wcyc(4);
    endtask

    initial begin
        int c0;
        wcyc(3);
        rst_n = 1;
        wcyc(1);
        cur_req = "R1";
        chk("R1 reset position", position, 0);
        chk("R1 reset index", index_count, 0);
        chk("R1 reset dir", dir_status, 1);
        chk("R1 reset events", {ev_phase_err, ev_dir_change, ev_enc_clk, ev_index}, 0);

        cur_req = "R2";
        repeat (6) qstep(1);
        chk("R2 x4 forward", position, 6);
        cur_req = "R8";
        repeat (2) qstep(0);
        chk("R2 x4 backward", position, 4);
        chk("R8 dir down", dir_status, 0);
        chk("R8 dir change count", n_dchg, 1);

        cur_req = "R3";
        cfg_x4 = 0;
        c0 = n_clk;
        repeat (4) qstep(1);
        chk("R3 x2 counts A only", position, 6);
        chk("R3 x2 enc clk pulses", n_clk - c0, 2);
        chk("R9 total enc clk", n_clk, 10);

        cur_req = "R6";
        set_ab(1, 1);
        chk("R6 error holds position", position, 6);
        chk("R6 error pulse", n_err, 1);
        chk("R6 error holds dir", dir_status, 1);

        cur_req = "R5";
        cfg_x4 = 1; cfg_dir_inv = 1; wcyc(2);
        qstep(1);
        chk("R5 inverted forward counts down", position, 5);
        chk("R5 inverted dir status", dir_status, 0);
        cfg_dir_inv = 0; wcyc(2);

        cur_req = "R11";
        strobe(0);
        chk("R11 clr_pos", position, 0);
        cur_req = "R7";
        qstep(0);
        chk("R7 wrap below zero", position, 20);
        chk("R13 match slot 2", ev_pos_match, 3'b100);
        qstep(1);
        chk("R7 wrap above max", position, 0);

        cur_req = "R10";
        pulse_index(); pulse_index();
        chk("R10 index count", index_count, 2);
        chk("R13 index match", ev_idx_match, 1);
        cfg_idx_inv = 1; wcyc(4);
        chk("R10 invert toggle no event", n_idx, 2);
        pulse_index();
        chk("R10 inverted pulse counted", index_count, 3);
        cfg_idx_inv = 0; wcyc(4);
        chk("R10 invert restore no event", index_count, 3);
        cur_req = "R11";
        strobe(1);
        chk("R11 clr_idx", index_count, 0);

        cur_req = "R12";
        repeat (3) qstep(1);
        chk("R13 match slot 0", ev_pos_match, 3'b001);
        strobe(2);
        repeat (2) qstep(1);
        chk("R12 armed still counts", position, 5);
        pulse_index();
        chk("R12 index clears position", position, 0);
        repeat (2) qstep(1);
        pulse_index();
        chk("R12 disarmed after use", position, 2);
        chk("R10 index after arm", index_count, 2);

        cur_req = "R4";
        cfg_clkdir = 1; wcyc(2);
        c0 = n_err;
        repeat (3) cd_pulse(1);
        chk("R4 clkdir up", position, 5);
        repeat (2) cd_pulse(0);
        chk("R4 clkdir down", position, 3);
        chk("R4 no phase error", n_err - c0, 0);
        wcyc(4);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule